// File: doc/BRIEF.md
# Mode-Switched Interleaving VRAM Controller

This controller sits between a video processor's 17-bit logical video-memory space and two physical 8-bit banks of 64 KiB each. It serves two clients. The first is a CPU data port, which reads and writes one byte at a time through an address pointer that steps forward after each access. The second is a display fetch port, which a raster counter drives. The physical banks sit outside the block. Each is a synchronous single-port RAM that returns read data one cycle after it samples the address.

A mode input selects one of two mappings. In the low-colour mapping, the logical address goes straight to the banks: the lower half of the logical space is in bank 0 and the upper half is in bank 1. In the high-colour mapping, even logical bytes are in bank 0 and odd logical bytes are in bank 1, both at offset address/2. A single display fetch then reads both banks in the same cycle and returns two neighbouring pixels. With 8 bits per pixel, pixel (X,Y) is at X + 256·Y + base, so a 256×212 picture covers logical bytes 0 to 54271.

A configuration input declares that only 64 KiB of memory is fitted. In that case the high-colour mapping is refused and flagged. Changing the mode never moves stored bytes, so data written under one mapping looks scrambled when it is read under the other.

Top module: `vram_mapper`

## Requirements
- R1: In the low-colour mapping (`hi_mode`=0, `only_64k`=0), logical address A selects bank A[16] at offset A[15:0]. Only that bank is enabled.
- R2: In the high-colour mapping (`hi_mode`=1, `only_64k`=0), a CPU access to logical address A selects bank A[0] at offset A[16:1]. Only that bank is enabled.
- R3: A byte written through the CPU port at logical address A reads back unchanged from A in either mapping, as long as the mapping does not change in between.
- R4: The pointer is set by `ptr_load`/`ptr_value`. It increases by one after every accepted CPU access and wraps from 0x1FFFF to 0.
- R5: While `fetch_req` is high, `cpu_ready` is low and no CPU access takes place: no bank write and no pointer step. `ptr_load` also holds `cpu_ready` low.
- R6: A high-colour fetch enables both banks at offset A[16:1] (A[0] is ignored). One cycle later it returns `fetch_data` = {bank 1 byte, bank 0 byte}, which is the even pixel in bits 7:0 and the odd pixel in bits 15:8.
- R7: A low-colour fetch reads one bank, mapped as in R1. One cycle later it returns the byte in bits 7:0, with bits 15:8 zero.
- R8: When `only_64k`=1, bank 1 is never enabled and every logical address maps to bank 0 at offset A[15:0]. If `hi_mode` is also 1, `mode_err` is high and the low-colour mapping is used instead.
- R9: Changing the mapping leaves bank contents untouched. A later read returns whatever the new mapping's physical location holds.
- R10: `cpu_rvalid` is high exactly in the cycle after an accepted CPU read, and carries the addressed byte.
- R11: After reset, `cpu_rvalid` and `fetch_valid` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_mode | input | 1 | 1 selects the interleaved high-colour mapping |
| only_64k | input | 1 | 1 declares that bank 1 is absent |
| mode_err | output | 1 | Interleaving requested without bank 1 |
| ptr_load | input | 1 | Load the CPU pointer |
| ptr_value | input | 17 | Value to load into the pointer |
| cpu_valid | input | 1 | CPU access request |
| cpu_ready | output | 1 | CPU access accepted this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | 8 | CPU read byte |
| fetch_req | input | 1 | Display fetch request |
| fetch_addr | input | 17 | Logical fetch address |
| fetch_valid | output | 1 | Fetch data valid |
| fetch_data | output | 16 | Fetched byte or byte pair |
| b0_en | output | 1 | Bank 0 enable |
| b0_we | output | 1 | Bank 0 write enable |
| b0_addr | output | 16 | Bank 0 address |
| b0_wdata | output | 8 | Bank 0 write data |
| b0_rdata | input | 8 | Bank 0 read data, one cycle after enable |
| b1_en | output | 1 | Bank 1 enable |
| b1_we | output | 1 | Bank 1 write enable |
| b1_addr | output | 16 | Bank 1 address |
| b1_wdata | output | 8 | Bank 1 write data |
| b1_rdata | input | 8 | Bank 1 read data, one cycle after enable |

## Verification
The bank enables, bank addresses, `cpu_ready` and `mode_err` are combinational. The bench checks them shortly after driving inputs on the falling edge, before the rising edge that accepts the request. Read bytes and fetch words come back through one bank register, so `cpu_rvalid`/`fetch_valid` and their data are checked on the falling edge after that accepting rising edge. A pointer step shows up on the next access: the bench checks the bank address of that access against its own copy of the pointer.

// File: rtl/vram_mapper.sv
module vram_mapper #(
  parameter int LA_W = 17,
  parameter int D_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_mode,
  input  logic              only_64k,
  output logic              mode_err,
  input  logic              ptr_load,
  input  logic [LA_W-1:0]   ptr_value,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [D_W-1:0]    cpu_wdata,
  output logic              cpu_rvalid,
  output logic [D_W-1:0]    cpu_rdata,
  input  logic              fetch_req,
  input  logic [LA_W-1:0]   fetch_addr,
  output logic              fetch_valid,
  output logic [2*D_W-1:0]  fetch_data,
  output logic              b0_en,
  output logic              b0_we,
  output logic [LA_W-2:0]   b0_addr,
  output logic [D_W-1:0]    b0_wdata,
  input  logic [D_W-1:0]    b0_rdata,
  output logic              b1_en,
  output logic              b1_we,
  output logic [LA_W-2:0]   b1_addr,
  output logic [D_W-1:0]    b1_wdata,
  input  logic [D_W-1:0]    b1_rdata
);
  localparam int PA_W = LA_W - 1;

  logic            split;
  logic            cpu_go;
  logic [LA_W-1:0] ptr_q;
  logic            cpu_bank, fetch_bank;
  logic [PA_W-1:0] cpu_off, fetch_off;
  logic            rd_q, rd_bank_q;
  logic            fv_q, fw_q, fb_q;

  assign split     = hi_mode & ~only_64k;
  assign mode_err  = hi_mode & only_64k;
  assign cpu_ready = ~fetch_req & ~ptr_load;
  assign cpu_go    = cpu_valid & cpu_ready;

  assign cpu_bank   = split ? ptr_q[0] : (ptr_q[LA_W-1] & ~only_64k);
  assign cpu_off    = split ? ptr_q[LA_W-1:1] : ptr_q[PA_W-1:0];
  assign fetch_bank = split ? fetch_addr[0] : (fetch_addr[LA_W-1] & ~only_64k);
  assign fetch_off  = split ? fetch_addr[LA_W-1:1] : fetch_addr[PA_W-1:0];

  assign b0_wdata = cpu_wdata;
  assign b1_wdata = cpu_wdata;

  always_comb begin
    b0_en = 1'b0; b1_en = 1'b0;
    b0_we = 1'b0; b1_we = 1'b0;
    b0_addr = cpu_off; b1_addr = cpu_off;
    if (fetch_req) begin
      b0_addr = fetch_off;
      b1_addr = fetch_off;
      b0_en   = split | ~fetch_bank;
      b1_en   = split | fetch_bank;
    end else if (cpu_go) begin
      b0_en = ~cpu_bank;
      b1_en = cpu_bank;
      b0_we = cpu_we & ~cpu_bank;
      b1_we = cpu_we & cpu_bank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      rd_q      <= 1'b0;
      rd_bank_q <= 1'b0;
      fv_q      <= 1'b0;
      fw_q      <= 1'b0;
      fb_q      <= 1'b0;
    end else begin
      if (ptr_load)    ptr_q <= ptr_value;
      else if (cpu_go) ptr_q <= ptr_q + 1'b1;
      rd_q      <= cpu_go & ~cpu_we;
      rd_bank_q <= cpu_bank;
      fv_q      <= fetch_req;
      fw_q      <= split;
      fb_q      <= fetch_bank;
    end
  end

  assign cpu_rvalid  = rd_q;
  assign cpu_rdata   = rd_bank_q ? b1_rdata : b0_rdata;
  assign fetch_valid = fv_q;
  assign fetch_data  = fw_q ? {b1_rdata, b0_rdata}
                            : {{D_W{1'b0}}, (fb_q ? b1_rdata : b0_rdata)};
endmodule

// File: rtl/vram_mapper_chk.sv
module vram_mapper_chk #(
  parameter int LA_W = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hi_mode,
  input logic            only_64k,
  input logic            mode_err,
  input logic            cpu_valid,
  input logic            cpu_ready,
  input logic            cpu_we,
  input logic            cpu_rvalid,
  input logic            ptr_load,
  input logic            fetch_req,
  input logic            fetch_valid,
  input logic            b0_en,
  input logic            b0_we,
  input logic            b1_en,
  input logic            b1_we,
  input logic [LA_W-1:0] ptr_q
);
  a_r5_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (!cpu_ready && !b0_we && !b1_we));

  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready) |=> (ptr_q == $past(ptr_q) + 1'b1));

  a_r6_both_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && hi_mode && !only_64k) |-> (b0_en && b1_en));

  a_r7_fetch_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> fetch_valid);

  a_r8_no_bank1: assert property (@(posedge clk) disable iff (!rst_n)
    only_64k |-> !b1_en);

  a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (hi_mode && only_64k));

  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && !cpu_we) |=> cpu_rvalid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_valid || !cpu_ready || cpu_we) |=> !cpu_rvalid);

  a_r2_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_req && !ptr_load && cpu_valid) |-> $onehot0({b0_en, b1_en}));
endmodule

bind vram_mapper vram_mapper_chk #(.LA_W(LA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_mode(hi_mode), .only_64k(only_64k),
  .mode_err(mode_err), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_we(cpu_we), .cpu_rvalid(cpu_rvalid), .ptr_load(ptr_load),
  .fetch_req(fetch_req), .fetch_valid(fetch_valid),
  .b0_en(b0_en), .b0_we(b0_we), .b1_en(b1_en), .b1_we(b1_we),
  .ptr_q(ptr_q)
);

// File: tb/vram_mapper_test.sv
`timescale 1ns/1ps
module vram_mapper_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_mode = 1'b0, only_64k = 1'b0, mode_err;
  logic ptr_load = 1'b0;
  logic [16:0] ptr_value = '0;
  logic cpu_valid = 1'b0, cpu_ready, cpu_we = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_rvalid;
  logic fetch_req = 1'b0;
  logic [16:0] fetch_addr = '0;
  logic fetch_valid;
  logic [15:0] fetch_data;
  logic b0_en, b0_we, b1_en, b1_we;
  logic [15:0] b0_addr, b1_addr;
  logic [7:0] b0_wdata, b1_wdata;
  logic [7:0] b0_rdata = '0, b1_rdata = '0;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [16:0] ptr_m = '0;
  logic [7:0] m0 [logic [15:0]];
  logic [7:0] m1 [logic [15:0]];
  logic [7:0] shadow [logic [16:0]];

  always #2 clk = ~clk;

  vram_mapper uut (.*);

  always @(posedge clk) begin
    if (b0_en) begin
      b0_rdata <= m0.exists(b0_addr) ? m0[b0_addr] : 8'h00;
      if (b0_we) m0[b0_addr] = b0_wdata;
    end
    if (b1_en) begin
      b1_rdata <= m1.exists(b1_addr) ? m1[b1_addr] : 8'h00;
      if (b1_we) m1[b1_addr] = b1_wdata;
    end
  end

  function automatic bit split_m();
    return hi_mode && !only_64k;
  endfunction
  function automatic bit bank_of(logic [16:0] a);
    return split_m() ? a[0] : (a[16] && !only_64k);
  endfunction
  function automatic logic [15:0] off_of(logic [16:0] a);
    return split_m() ? a[16:1] : a[15:0];
  endfunction
  function automatic logic [7:0] sh_rd(bit b, logic [15:0] o);
    return shadow.exists({b, o}) ? shadow[{b, o}] : 8'h00;
  endfunction
  function automatic string map_tag();
    return only_64k ? "R8" : (hi_mode ? "R2" : "R1");
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(bit h, bit s);
    @(negedge clk);
    hi_mode = h; only_64k = s;
    #1 chk(mode_err == (h && s), "R8 mode_err", {31'd0, mode_err}, {31'd0, h && s});
  endtask

  task automatic set_ptr(logic [16:0] a);
    @(negedge clk);
    ptr_load = 1'b1; ptr_value = a; cpu_valid = 1'b1; cpu_we = 1'b1;
    #1 chk(!cpu_ready && !b0_we && !b1_we, "R5 load blocks cpu", {31'd0, cpu_ready}, 32'd0);
    @(negedge clk);
    ptr_load = 1'b0; cpu_valid = 1'b0;
    ptr_m = a;
  endtask

  task automatic cpu_op(bit we, logic [7:0] d);
    bit b; logic [15:0] o; bit ok; string tg;
    b = bank_of(ptr_m); o = off_of(ptr_m); tg = map_tag();
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_wdata = d;
    #1;
    chk(cpu_ready, "R5 ready when idle", {31'd0, cpu_ready}, 32'd1);
    if (b) ok = b1_en && !b0_en && b1_addr == o && b1_we == we;
    else   ok = b0_en && !b1_en && b0_addr == o && b0_we == we;
    chk(ok, tg, {b1_en, b0_en, (b ? b1_addr : b0_addr)}, {!b ? 2'b01 : 2'b10, o});
    @(posedge clk);
    if (we) shadow[{b, o}] = d;
    @(negedge clk);
    cpu_valid = 1'b0;
    if (!we) begin
      chk(cpu_rvalid, "R10 rvalid", {31'd0, cpu_rvalid}, 32'd1);
      chk(cpu_rdata == sh_rd(b, o), "R3 R9 readback", {24'd0, cpu_rdata}, {24'd0, sh_rd(b, o)});
    end else
      chk(!cpu_rvalid, "R10 no rvalid on write", {31'd0, cpu_rvalid}, 32'd0);
    ptr_m = ptr_m + 1'b1;
  endtask

  task automatic fetch(logic [16:0] a);
    logic [15:0] exp; bit wide; bit b; logic [15:0] o;
    wide = split_m(); b = bank_of(a); o = off_of(a);
    exp = wide ? {sh_rd(1'b1, o), sh_rd(1'b0, o)} : {8'h00, sh_rd(b, o)};
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a;
    cpu_valid = 1'b1; cpu_we = 1'b1; cpu_wdata = 8'hEE;
    #1;
    chk(!cpu_ready && !b0_we && !b1_we, "R5 fetch wins", {31'd0, cpu_ready}, 32'd0);
    if (wide)
      chk(b0_en && b1_en && b0_addr == o && b1_addr == o, "R6 both banks",
          {b1_en, b0_en, b0_addr}, {2'b11, o});
    @(negedge clk);
    fetch_req = 1'b0; cpu_valid = 1'b0;
    chk(fetch_valid, "R7 fetch_valid", {31'd0, fetch_valid}, 32'd1);
    chk(fetch_data == exp, wide ? "R6 pair" : "R7 byte", {16'd0, fetch_data}, {16'd0, exp});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1 chk(!cpu_rvalid && !fetch_valid, "R11 reset outputs",
           {30'd0, cpu_rvalid, fetch_valid}, 32'd0);
    rst_n = 1'b1;
    cpu_op(1'b1, 8'h5A);
    chk(shadow.exists(17'd0), "R11 pointer starts at 0", 32'd0, 32'd0);
    set_mode(1'b1, 1'b0);
    set_ptr(17'd0);
    for (int i = 0; i < 256; i++) cpu_op(1'b1, i[7:0]);
    chk(m0[16'd2] == 8'd4 && m1[16'd2] == 8'd5, "R2 even/odd split",
        {m1[16'd2], m0[16'd2]}, {8'd5, 8'd4});
    fetch(17'd0);
    fetch(17'd7);
    set_ptr(17'd54271);
    cpu_op(1'b1, 8'hC3);
    chk(m1.exists(16'd27135) && m1[16'd27135] == 8'hC3, "R2 last pixel", 32'd0, 32'd0);
    set_ptr(17'd54271);
    cpu_op(1'b0, 8'h00);
    set_ptr(17'h1FFFF);
    cpu_op(1'b1, 8'h11);
    cpu_op(1'b1, 8'h22);
    set_mode(1'b0, 1'b0);
    set_ptr(17'd1);
    cpu_op(1'b0, 8'h00);
    fetch(17'd2);
    fetch(17'h10005);
    set_mode(1'b1, 1'b1);
    set_ptr(17'h10003);
    cpu_op(1'b1, 8'h77);
    cpu_op(1'b0, 8'h00);
    fetch(17'h10003);
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      op = $urandom % 10;
      if (op < 4) cpu_op(1'b1, 8'($urandom));
      else if (op < 7) cpu_op(1'b0, 8'h00);
      else if (op == 7) fetch(17'(($urandom % 2) * 17'h10000 + ($urandom % 64)));
      else if (op == 8) set_ptr(17'(($urandom % 2) * 17'h10000 + ($urandom % 64)));
      else set_mode(1'($urandom), ($urandom % 4) == 0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule